// File: doc/BRIEF.md
# Serial Port Resource Selector

This block sits on a plug-free serial expansion card and turns one configuration byte, written by the card's local controller, into the card's ISA bus resources. The low six bits of the byte choose one of eight classic 8-byte COM I/O windows and one of eight interrupt lines. Bit 7 turns the selection on. Bit 6 is a flag asking firmware to store the present choice as the power-on default.

On the bus side, the block compares the ISA address against the chosen window while AEN is low. It then gives a chip-select, qualified read and write strobes, and the register offset inside the window. On the interrupt side, it sends one internal request to exactly one of eight IRQ pins. When a plug-and-play initiation key is detected, the block leaves this jumperless mode, and the bus decode and interrupt pins go quiet.

Top module: `com_autocfg`

## Requirements
- R1: Config bits 2:0 route the interrupt. The codes 0 to 7 drive irq_o[0] to irq_o[7], and these stand for IRQ 3, 4, 5, 7, 10, 11, 12 and 15. The selected pin equals irq_req_i.
- R2: Config bits 5:3 pick the I/O base. The codes 0 to 7 give 3F8h, 2F8h, 3E8h, 2E8h, 3F0h, 2F0h, 3E0h and 2E0h. cs_o is high only when addr_i[11:3] equals base[11:3].
- R3: At most one bit of irq_o is high at any time. Every pin that is not selected stays low.
- R4: cs_o also needs aen_i low and at least one of ior_ni or iow_ni low. rd_o equals cs_o with ior_ni low, and wr_o equals cs_o with iow_ni low.
- R5: A pulse on pnp_key_i clears config bit 7 on the next clock edge. It wins over a controller write in the same cycle and leaves bits 6:0 as written.
- R6: A pulse on save_req_i sets config bit 6. Only a controller write with bit 6 at 0 clears it. A key event leaves it unchanged.
- R7: Asynchronous reset loads RESET_CFG (default 80h: enabled, COM base 3F8h, IRQ3).
- R8: cfg_rdata_o always shows the current configuration byte. A write updates it on the following clock edge.
- R9: While config bit 7 is 0, cs_o, rd_o, wr_o and all bits of irq_o are held low.
- R10: reg_off_o equals addr_i[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Controller write strobe for the config byte |
| cfg_wdata_i | input | 8 | Config byte to write |
| cfg_rdata_o | output | 8 | Current config byte |
| save_req_i | input | 1 | Pulse that sets the save-default flag |
| pnp_key_i | input | 1 | Pulse on plug-and-play initiation key detection |
| addr_i | input | 12 | ISA address bits 11:0 |
| aen_i | input | 1 | ISA address enable; decoding occurs only while low |
| ior_ni | input | 1 | ISA I/O read strobe, active low |
| iow_ni | input | 1 | ISA I/O write strobe, active low |
| cs_o | output | 1 | Window selected by an I/O cycle |
| rd_o | output | 1 | Qualified read strobe |
| wr_o | output | 1 | Qualified write strobe |
| reg_off_o | output | 3 | Register offset within the window |
| irq_req_i | input | 1 | Internal interrupt request |
| irq_o | output | 8 | IRQ pins, order 3, 4, 5, 7, 10, 11, 12, 15 |

## Verification
The assertions assume that pnp_key_i and save_req_i are single-cycle pulses. They also assume that the bus inputs change only between controller clock edges, so the combinational decode is stable when sampled. The bench drives every input on the falling edge and samples one time unit later. Key and save pulses last exactly one cycle. The sweep covers all 64 selections against every address in the 200h to 3FFh range, with both AEN levels and both strobes.

// File: rtl/com_autocfg_pkg.sv
package com_autocfg_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_SEL  = 1 << SEL_W;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned OFF_W  = 3;

  typedef struct packed {
    logic             en;
    logic             save;
    logic [SEL_W-1:0] base_sel;
    logic [SEL_W-1:0] irq_sel;
  } cfg_t;

  // code bit0 -> 3xx/2xx, bit1 -> xFx/xEx, bit2 -> xx8/xx0
  function automatic logic [ADDR_W-1:OFF_W] base_of(input logic [SEL_W-1:0] s);
    logic [ADDR_W-1:0] b;
    b = 12'h2E0;
    b[8] = ~s[0];
    b[4] = ~s[1];
    b[3] = ~s[2];
    return b[ADDR_W-1:OFF_W];
  endfunction
endpackage

// File: rtl/com_cfg_reg.sv
module com_cfg_reg
  import com_autocfg_pkg::*;
#(
  parameter logic [7:0] RESET_CFG = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       save_req_i,
  input  logic       pnp_key_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= cfg_t'(RESET_CFG);
    end else begin
      if (wr_i) cfg_q <= cfg_t'(wdata_i);
      if (save_req_i) cfg_q.save <= 1'b1;
      if (pnp_key_i) cfg_q.en <= 1'b0;  // key overrides a same-cycle write
    end
  end

  assign cfg_o = cfg_q;

  AST_KEY_DROPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pnp_key_i |=> !cfg_q.en); // R5
  AST_SAVE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.save && !wr_i) |=> cfg_q.save); // R6
endmodule

// File: rtl/com_addr_dec.sv
module com_addr_dec
  import com_autocfg_pkg::*;
(
  input  logic              en_i,
  input  logic [SEL_W-1:0]  base_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [OFF_W-1:0]  reg_off_o
);
  logic hit;

  assign hit       = (addr_i[ADDR_W-1:OFF_W] == base_of(base_sel_i));
  assign cs_o      = en_i && !aen_i && hit && (!ior_ni || !iow_ni);
  assign rd_o      = cs_o && !ior_ni;
  assign wr_o      = cs_o && !iow_ni;
  assign reg_off_o = addr_i[OFF_W-1:0];

  always_comb begin
    if (aen_i) AST_AEN_BLOCKS: assert (!cs_o); // R4
  end
endmodule

// File: rtl/com_irq_route.sv
module com_irq_route
  import com_autocfg_pkg::*;
(
  input  logic             en_i,
  input  logic [SEL_W-1:0] irq_sel_i,
  input  logic             req_i,
  output logic [N_SEL-1:0] irq_o
);
  for (genvar i = 0; i < N_SEL; i++) begin : g_pin
    assign irq_o[i] = en_i && req_i && (irq_sel_i == SEL_W'(i));
  end

  always_comb begin
    AST_IRQ_ONEHOT: assert ($onehot0(irq_o)); // R3
  end
endmodule

// File: rtl/com_autocfg.sv
module com_autocfg
  import com_autocfg_pkg::*;
#(
  parameter logic [7:0] RESET_CFG = 8'h80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              save_req_i,
  input  logic              pnp_key_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [OFF_W-1:0]  reg_off_o,
  input  logic              irq_req_i,
  output logic [N_SEL-1:0]  irq_o
);
  cfg_t cfg;

  com_cfg_reg #(.RESET_CFG(RESET_CFG)) u_cfg (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
    .save_req_i, .pnp_key_i, .cfg_o(cfg)
  );

  com_addr_dec u_dec (
    .en_i(cfg.en), .base_sel_i(cfg.base_sel), .addr_i, .aen_i,
    .ior_ni, .iow_ni, .cs_o, .rd_o, .wr_o, .reg_off_o
  );

  com_irq_route u_irq (
    .en_i(cfg.en), .irq_sel_i(cfg.irq_sel), .req_i(irq_req_i), .irq_o
  );

  assign cfg_rdata_o = cfg;

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rdata_o[7] |-> (irq_o == '0 && !cs_o)); // R9
endmodule

// File: tb/com_autocfg_test.sv
`timescale 1ns/1ps
module com_autocfg_test;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0, save_req = 0, pnp_key = 0;
  logic [7:0]  cfg_wdata = 0, cfg_rdata;
  logic [11:0] addr = 0;
  logic        aen = 0, ior_n = 1, iow_n = 1, irq_req = 0;
  logic        cs, rd, wr;
  logic [2:0]  reg_off;
  logic [7:0]  irq;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  com_autocfg uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .save_req_i(save_req), .pnp_key_i(pnp_key),
    .addr_i(addr), .aen_i(aen), .ior_ni(ior_n), .iow_ni(iow_n),
    .cs_o(cs), .rd_o(rd), .wr_o(wr), .reg_off_o(reg_off),
    .irq_req_i(irq_req), .irq_o(irq)
  );

  function automatic logic [11:0] base_exp(input int s);
    case (s)
      0: return 12'h3F8; 1: return 12'h2F8; 2: return 12'h3E8; 3: return 12'h2E8;
      4: return 12'h3F0; 5: return 12'h2F0; 6: return 12'h3E0; default: return 12'h2E0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] d, input logic key = 0);
    @(negedge clk); cfg_wr = 1; cfg_wdata = d; pnp_key = key;
    @(negedge clk); cfg_wr = 0; pnp_key = 0; #1;
  endtask

  task automatic pulse_save();
    @(negedge clk); save_req = 1;
    @(negedge clk); save_req = 0; #1;
  endtask

  task automatic pulse_key();
    @(negedge clk); pnp_key = 1;
    @(negedge clk); pnp_key = 0; #1;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    #22 rst_n = 1;
    @(negedge clk); #1;
    chk(cfg_rdata == 8'h80, "R7 reset value", cfg_rdata, 8'h80);
    addr = 12'h3FD; ior_n = 0; #1;
    chk(cs && rd && !wr, "R7 reset decode COM1", {cs, rd, wr}, 3'b110);
    irq_req = 1; #1;
    chk(irq == 8'h01, "R7 reset IRQ3", irq, 8'h01);
    irq_req = 0; ior_n = 1;

    // full sweep of selections, addresses, strobes and AEN
    for (int s = 0; s < 64; s++) begin
      wr_cfg({2'b10, 6'(s)});
      chk(cfg_rdata == {2'b10, 6'(s)}, "R8 readback", cfg_rdata, {2'b10, 6'(s)});
      irq_req = 1; #1;
      chk(irq == (8'h1 << (s % 8)), "R1 irq route", irq, 8'h1 << (s % 8));
      chk($countones(irq) == 1, "R3 single irq", irq, 8'h1 << (s % 8));
      irq_req = 0; #1;
      chk(irq == 0, "R1 irq follows request", irq, 0);
      for (int a = 12'h200; a < 12'h400; a++) begin
        logic hit;
        addr = 12'(a);
        hit = (12'(a) >> 3) == (base_exp(s / 8) >> 3);
        ior_n = 0; iow_n = 1; aen = 0; #1;
        chk(cs == hit && rd == hit && !wr, "R2 read decode", {cs, rd, wr}, {hit, hit, 1'b0});
        chk(reg_off == 3'(a), "R10 offset", reg_off, 3'(a));
        ior_n = 1; iow_n = 0; #1;
        chk(cs == hit && wr == hit && !rd, "R2 write decode", {cs, rd, wr}, {hit, 1'b0, hit});
        aen = 1; #1;
        chk(!cs && !wr, "R4 aen blocks", {cs, wr}, 0);
        aen = 0; iow_n = 1; #1;
        chk(!cs, "R4 no strobe", cs, 0);
      end
    end

    // disabled: all quiet
    wr_cfg(8'h00);
    addr = 12'h3F8; ior_n = 0; irq_req = 1; #1;
    chk(!cs && !rd && irq == 0, "R9 disabled quiet", {cs, rd, irq}, 0);
    ior_n = 1; irq_req = 0;

    // key event
    wr_cfg(8'h9B);
    pulse_key();
    chk(cfg_rdata == 8'h1B, "R5 key clears enable", cfg_rdata, 8'h1B);
    addr = 12'h2E8; ior_n = 0; irq_req = 1; #1;
    chk(!cs && irq == 0, "R9 after key quiet", {cs, irq}, 0);
    ior_n = 1; irq_req = 0;
    wr_cfg(8'h85, 1'b1);
    chk(cfg_rdata == 8'h05, "R5 key beats write", cfg_rdata, 8'h05);

    // save flag
    wr_cfg(8'h82);
    pulse_save();
    chk(cfg_rdata == 8'hC2, "R6 save sets", cfg_rdata, 8'hC2);
    pulse_key();
    chk(cfg_rdata == 8'h42, "R6 key keeps save", cfg_rdata, 8'h42);
    wr_cfg(8'hC3);
    chk(cfg_rdata == 8'hC3, "R6 write one keeps", cfg_rdata, 8'hC3);
    wr_cfg(8'h83);
    chk(cfg_rdata == 8'h83, "R6 controller clears", cfg_rdata, 8'h83);

    // async reset restores default
    wr_cfg(8'h3F);
    #2 rst_n = 0; #1;
    chk(cfg_rdata == 8'h80, "R7 async reset", cfg_rdata, 8'h80);
    #10 rst_n = 1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule